// File: doc/BRIEF.md
# Single-Precision Fused Multiply-Add Issue and Flag Unit

This block sits between the instruction stream and an external single-precision multiply-add core. It accepts one instruction at a time. It recognises the four fused multiply-add variants and pulls out the three source register indices, the destination index and the rounding field. It then hands the core three operands and a resolved rounding mode.

All four variants run on the same `(a * b) + c` core. The block reaches each variant by inverting the sign bit of the first operand, the third operand, or both, before the operands leave the block. A rounding field that asks for the dynamic mode takes its value from the rounding-mode field of the control register, which arrives on a plain input.

Encodings that cannot execute raise a one-cycle illegal pulse and never reach the core. When the core returns a result, the block writes it to the destination register through a registered write port. It also merges the returned exception flags into a sticky accrued-flags register.

There are two streaming interfaces, and both use valid/ready. On each one a transfer happens on a rising edge where valid and ready are both high. Whoever raises valid keeps it high, with its payload unchanged, until that transfer happens. The block's ready signals depend only on its own state, never on the matching valid. Only one of the three stages (accepting an instruction, offering operands, awaiting a result) is active at any time. This gives natural back-pressure: no new instruction is accepted until the previous one has written back.

Top module: `fma_issue_unit`

## Requirements
- R1: `issue_rs3`, `issue_rs2` and `issue_rs1` show bits 31:27, 24:20 and 19:15 of `issue_instr` combinationally. The destination index is taken from bits 11:7 and the rounding field from bits 14:12.
- R2: The opcode in bits 6:0 selects the operand signs sent to the core. 1000011 passes a, b and c unchanged. 1000111 inverts c. 1001011 inverts a. 1001111 inverts both a and c. Only bit 31 is inverted, whatever the operand is (including NaN and infinity), and b always passes unchanged.
- R3: Rounding field values 000 to 100 are sent to `core_rm` as they are. The value 111 sends `frm_dyn` as it stood at acceptance.
- R4: An accepted instruction is illegal in any of these cases: its opcode is not one of the four in R2; bits 26:25 are not 00; the rounding field is 101 or 110; or the field is 111 and `frm_dyn` is 101, 110 or 111. An illegal instruction raises `instr_illegal` for exactly the cycle after acceptance. It makes no core request and no register write, and it leaves the flags unchanged.
- R5: `issue_ready` is high only when the block is idle. `core_valid`, once raised, stays high with stable `core_a`, `core_b`, `core_c` and `core_rm` until `core_ready` is seen.
- R6: `res_ready` is high only after the operand transfer and before the result transfer. The cycle after a result transfer, `rf_we` is high for exactly one cycle, with `rf_waddr` equal to the destination index and `rf_wdata` equal to the result.
- R7: `fflags_acc` takes the bitwise OR of its old value and `res_flags` on each result transfer, and changes at no other time. `res_flags` offered while `res_ready` is low has no effect.
- R8: Latency does not depend on operand values. A legal instruction raises `core_valid` in the cycle after acceptance. The write happens in the cycle after the result transfer. The block is idle again in that same cycle.
- R9: While reset is low and after it is released, the block is idle. `issue_ready` is high; `core_valid`, `res_ready`, `rf_we` and `instr_illegal` are low; and `fflags_acc` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| frm_dyn | input | 3 | Dynamic rounding-mode field of the control register |
| issue_valid | input | 1 | Instruction offered |
| issue_ready | output | 1 | Block can accept an instruction |
| issue_instr | input | 32 | Instruction word |
| issue_a | input | 32 | Value of first source register |
| issue_b | input | 32 | Value of second source register |
| issue_c | input | 32 | Value of third source register |
| issue_rs1 | output | 5 | First source index for register read |
| issue_rs2 | output | 5 | Second source index for register read |
| issue_rs3 | output | 5 | Third source index for register read |
| core_valid | output | 1 | Operands offered to the core |
| core_ready | input | 1 | Core accepts operands |
| core_a | output | 32 | Multiplicand after sign adjustment |
| core_b | output | 32 | Multiplier |
| core_c | output | 32 | Addend after sign adjustment |
| core_rm | output | 3 | Resolved rounding mode |
| res_valid | input | 1 | Core offers a result |
| res_ready | output | 1 | Block accepts a result |
| res_value | input | 32 | Rounded result from the core |
| res_flags | input | 5 | Exception flags from the core |
| rf_we | output | 1 | Destination register write enable |
| rf_waddr | output | 5 | Destination register index |
| rf_wdata | output | 32 | Destination register data |
| instr_illegal | output | 1 | One-cycle illegal-instruction pulse |
| fflags_acc | output | 5 | Sticky accrued exception flags |

## Verification
The bench sweeps all four variants against all eight rounding-field values, and sweeps every dynamic-mode value wherever the field asks for it. A design that confused the inversion pairs would send a wrong sign on `core_a` or `core_c`; operands that are NaN or infinity show whether more than bit 31 was touched. A decoder that accepted reserved rounding values, or that took the instruction field in place of `frm_dyn`, would request the core when it should pulse illegal, or would show the wrong `core_rm`. The core's responses are stretched by zero to two cycles at both handshakes, to catch payloads that change while stalled and write pulses that come a cycle early or late. Flags offered while no result is expected, and illegal instructions followed by flag traffic, expose accrual that is not gated on retirement.

// File: rtl/fma_issue_pkg.sv
package fma_issue_pkg;
  localparam int INSTR_W   = 32;
  localparam int REG_IDX_W = 5;
  localparam int RM_W      = 3;
  localparam int FLAG_W    = 5;
  localparam int NUM_OPS   = 3;

  localparam logic [6:0] OPC_MADD  = 7'b1000011;
  localparam logic [6:0] OPC_MSUB  = 7'b1000111;
  localparam logic [6:0] OPC_NMSUB = 7'b1001011;
  localparam logic [6:0] OPC_NMADD = 7'b1001111;

  localparam logic [RM_W-1:0] RM_DYNAMIC = 3'b111;
  localparam logic [RM_W-1:0] RM_MAX_OK  = 3'b100;

  typedef enum logic [1:0] {
    VAR_MADD  = 2'd0,
    VAR_MSUB  = 2'd1,
    VAR_NMSUB = 2'd2,
    VAR_NMADD = 2'd3
  } fma_variant_e;

  typedef struct packed {
    logic [REG_IDX_W-1:0] rs1;
    logic [REG_IDX_W-1:0] rs2;
    logic [REG_IDX_W-1:0] rs3;
    logic [REG_IDX_W-1:0] rd;
    logic [RM_W-1:0]      rm;
    fma_variant_e         variant;
    logic                 legal;
  } fma_dec_t;

  // bit 0: invert multiplicand, bit 1: multiplier (never), bit 2: addend
  function automatic logic [NUM_OPS-1:0] variant_flips(fma_variant_e v);
    case (v)
      VAR_MSUB:  return 3'b100;
      VAR_NMSUB: return 3'b001;
      VAR_NMADD: return 3'b101;
      default:   return 3'b000;
    endcase
  endfunction
endpackage

// File: rtl/fma_decode.sv
module fma_decode
  import fma_issue_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  input  logic [RM_W-1:0]    frm_dyn,
  output fma_dec_t           dec
);
  logic [6:0]      opc;
  logic [1:0]      fmt;
  logic [RM_W-1:0] rm_field;
  logic [RM_W-1:0] rm_eff;
  logic            opc_ok;
  fma_variant_e    var_sel;

  assign opc      = instr[6:0];
  assign fmt      = instr[26:25];
  assign rm_field = instr[14:12];

  always_comb begin
    opc_ok  = 1'b1;
    var_sel = VAR_MADD;
    case (opc)
      OPC_MADD:  var_sel = VAR_MADD;
      OPC_MSUB:  var_sel = VAR_MSUB;
      OPC_NMSUB: var_sel = VAR_NMSUB;
      OPC_NMADD: var_sel = VAR_NMADD;
      default:   opc_ok  = 1'b0;
    endcase
  end

  // dynamic selection substitutes the control-register field; the
  // substituted value goes through the same range test
  assign rm_eff = (rm_field == RM_DYNAMIC) ? frm_dyn : rm_field;

  always_comb begin
    dec.rs3     = instr[31:27];
    dec.rs2     = instr[24:20];
    dec.rs1     = instr[19:15];
    dec.rd      = instr[11:7];
    dec.rm      = rm_eff;
    dec.variant = var_sel;
    dec.legal   = opc_ok && (fmt == 2'b00) && (rm_eff <= RM_MAX_OK);
  end
endmodule

// File: rtl/fma_sign_prep.sv
module fma_sign_prep
  import fma_issue_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fma_variant_e                    variant,
  input  logic [NUM_OPS-1:0][DATA_W-1:0] op_in,
  output logic [NUM_OPS-1:0][DATA_W-1:0] op_out
);
  localparam int SIGN_BIT = DATA_W - 1;

  logic [NUM_OPS-1:0] flips;
  assign flips = variant_flips(variant);

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
    assign op_out[g] = {op_in[g][SIGN_BIT] ^ flips[g], op_in[g][SIGN_BIT-1:0]};
  end
endmodule

// File: rtl/fma_flag_accum.sv
module fma_flag_accum
  import fma_issue_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [FLAG_W-1:0] flags_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      flags_q <= '0;
    else if (acc_en) flags_q <= flags_q | flags_in;
  end

  p_flags_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  p_flags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_en |=> $stable(flags_q));
endmodule

// File: rtl/fma_issue_unit.sv
module fma_issue_unit
  import fma_issue_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [RM_W-1:0]      frm_dyn,
  input  logic                 issue_valid,
  output logic                 issue_ready,
  input  logic [INSTR_W-1:0]   issue_instr,
  input  logic [DATA_W-1:0]    issue_a,
  input  logic [DATA_W-1:0]    issue_b,
  input  logic [DATA_W-1:0]    issue_c,
  output logic [REG_IDX_W-1:0] issue_rs1,
  output logic [REG_IDX_W-1:0] issue_rs2,
  output logic [REG_IDX_W-1:0] issue_rs3,
  output logic                 core_valid,
  input  logic                 core_ready,
  output logic [DATA_W-1:0]    core_a,
  output logic [DATA_W-1:0]    core_b,
  output logic [DATA_W-1:0]    core_c,
  output logic [RM_W-1:0]      core_rm,
  input  logic                 res_valid,
  output logic                 res_ready,
  input  logic [DATA_W-1:0]    res_value,
  input  logic [FLAG_W-1:0]    res_flags,
  output logic                 rf_we,
  output logic [REG_IDX_W-1:0] rf_waddr,
  output logic [DATA_W-1:0]    rf_wdata,
  output logic                 instr_illegal,
  output logic [FLAG_W-1:0]    fflags_acc
);
  typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_WAIT} state_e;

  state_e                         state_q;
  fma_dec_t                       dec;
  logic [NUM_OPS-1:0][DATA_W-1:0] ops_raw;
  logic [NUM_OPS-1:0][DATA_W-1:0] ops_adj;
  logic [NUM_OPS-1:0][DATA_W-1:0] ops_q;
  logic [RM_W-1:0]                rm_q;
  logic [REG_IDX_W-1:0]           rd_q;
  logic                           accept;
  logic                           send_fire;
  logic                           res_fire;
  logic                           illegal_q;
  logic                           we_q;
  logic [REG_IDX_W-1:0]           waddr_q;
  logic [DATA_W-1:0]              wdata_q;

  fma_decode u_decode (
    .instr   (issue_instr),
    .frm_dyn (frm_dyn),
    .dec     (dec)
  );

  assign ops_raw[0] = issue_a;
  assign ops_raw[1] = issue_b;
  assign ops_raw[2] = issue_c;

  fma_sign_prep #(.DATA_W(DATA_W)) u_sign (
    .variant (dec.variant),
    .op_in   (ops_raw),
    .op_out  (ops_adj)
  );

  assign issue_rs1 = dec.rs1;
  assign issue_rs2 = dec.rs2;
  assign issue_rs3 = dec.rs3;

  assign issue_ready = (state_q == ST_IDLE);
  assign core_valid  = (state_q == ST_SEND);
  assign res_ready   = (state_q == ST_WAIT);
  assign accept      = issue_valid && issue_ready;
  assign send_fire   = core_valid && core_ready;
  assign res_fire    = res_valid && res_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= accept && !dec.legal;
      case (state_q)
        ST_IDLE: if (accept && dec.legal) state_q <= ST_SEND;
        ST_SEND: if (send_fire)           state_q <= ST_WAIT;
        ST_WAIT: if (res_fire)            state_q <= ST_IDLE;
        default:                          state_q <= ST_IDLE;
      endcase
    end
  end

  // operand capture; held unchanged while the core stalls
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ops_q <= '0;
      rm_q  <= '0;
      rd_q  <= '0;
    end else if (accept && dec.legal) begin
      ops_q <= ops_adj;
      rm_q  <= dec.rm;
      rd_q  <= dec.rd;
    end
  end

  assign core_a  = ops_q[0];
  assign core_b  = ops_q[1];
  assign core_c  = ops_q[2];
  assign core_rm = rm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      we_q <= res_fire;
      if (res_fire) begin
        waddr_q <= rd_q;
        wdata_q <= res_value;
      end
    end
  end

  assign rf_we         = we_q;
  assign rf_waddr      = waddr_q;
  assign rf_wdata      = wdata_q;
  assign instr_illegal = illegal_q;

  fma_flag_accum u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_en   (res_fire),
    .flags_in (res_flags),
    .flags_q  (fflags_acc)
  );

  p_core_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    core_valid && !core_ready |=> core_valid && $stable({core_a, core_b, core_c, core_rm}));

  p_one_stage_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({issue_ready, core_valid, res_ready}));

  p_illegal_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    instr_illegal |-> !core_valid && !rf_we && issue_ready);

  p_wb_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
    res_fire |=> rf_we && issue_ready);

  p_wb_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);

  p_fixed_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
    accept && dec.legal |=> core_valid);

  p_illegal_rm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && (dec.rm > RM_MAX_OK) |=> instr_illegal && !core_valid);
endmodule

// File: tb/fma_issue_unit_tb.sv
`timescale 1ns/1ps
module fma_issue_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  frm_dyn = '0;
  logic        issue_valid = 1'b0;
  logic        issue_ready;
  logic [31:0] issue_instr = '0;
  logic [31:0] issue_a = '0, issue_b = '0, issue_c = '0;
  logic [4:0]  issue_rs1, issue_rs2, issue_rs3;
  logic        core_valid;
  logic        core_ready = 1'b0;
  logic [31:0] core_a, core_b, core_c;
  logic [2:0]  core_rm;
  logic        res_valid = 1'b0;
  logic        res_ready;
  logic [31:0] res_value = '0;
  logic [4:0]  res_flags = '0;
  logic        rf_we;
  logic [4:0]  rf_waddr;
  logic [31:0] rf_wdata;
  logic        instr_illegal;
  logic [4:0]  fflags_acc;

  int checks = 0;
  int errors = 0;
  logic [4:0] flags_exp = '0;

  always #5 clk = ~clk;

  fma_issue_unit u_dut (
    .clk(clk), .rst_n(rst_n), .frm_dyn(frm_dyn),
    .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_instr(issue_instr),
    .issue_a(issue_a), .issue_b(issue_b), .issue_c(issue_c),
    .issue_rs1(issue_rs1), .issue_rs2(issue_rs2), .issue_rs3(issue_rs3),
    .core_valid(core_valid), .core_ready(core_ready),
    .core_a(core_a), .core_b(core_b), .core_c(core_c), .core_rm(core_rm),
    .res_valid(res_valid), .res_ready(res_ready), .res_value(res_value), .res_flags(res_flags),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .instr_illegal(instr_illegal), .fflags_acc(fflags_acc)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R9 ready in reset", {31'd0, issue_ready}, 32'd1);
    chk("R9 outputs quiet in reset", {28'd0, core_valid, res_ready, rf_we, instr_illegal}, 32'd0);
    chk("R9 flags zero", {27'd0, fflags_acc}, 32'd0);
    rst_n = 1'b1;
    flags_exp = '0;
    @(negedge clk);
    chk("R9 idle after release", {29'd0, issue_ready, core_valid, res_ready}, 32'd4);
  endtask

  // entered and left at a falling edge
  task automatic run_op(input logic [6:0] opc, input logic [1:0] fmt,
                        input logic [2:0] rm, input logic [2:0] frm,
                        input logic [4:0] rd, input logic [4:0] r1,
                        input logic [4:0] r2, input logic [4:0] r3,
                        input logic [31:0] a, input logic [31:0] b,
                        input logic [31:0] c, input int cdly, input int rdly,
                        input logic [31:0] rv, input logic [4:0] rf);
    logic       op_ok, legal, fa, fc;
    logic [2:0] eff;
    op_ok = (opc == 7'b1000011) || (opc == 7'b1000111) ||
            (opc == 7'b1001011) || (opc == 7'b1001111);
    eff   = (rm == 3'b111) ? frm : rm;
    legal = op_ok && (fmt == 2'b00) && (eff <= 3'b100);
    fa    = (opc == 7'b1001011) || (opc == 7'b1001111);
    fc    = (opc == 7'b1000111) || (opc == 7'b1001111);

    frm_dyn     = frm;
    issue_a     = a;
    issue_b     = b;
    issue_c     = c;
    issue_instr = {r3, fmt, r2, r1, rm, rd, opc};
    issue_valid = 1'b1;
    #1;
    chk("R1 rs1 index", {27'd0, issue_rs1}, {27'd0, r1});
    chk("R1 rs2 index", {27'd0, issue_rs2}, {27'd0, r2});
    chk("R1 rs3 index", {27'd0, issue_rs3}, {27'd0, r3});
    chk("R5 ready when idle", {31'd0, issue_ready}, 32'd1);
    @(posedge clk);
    @(negedge clk);
    issue_valid = 1'b0;
    frm_dyn     = ~frm;
    if (!legal) begin
      chk("R4 illegal pulse", {31'd0, instr_illegal}, 32'd1);
      chk("R4 no core request", {31'd0, core_valid}, 32'd0);
      // flags offered while no result is awaited must be dropped
      res_valid = 1'b1;
      res_flags = 5'h1f;
      res_value = 32'hdead_beef;
      @(posedge clk);
      @(negedge clk);
      res_valid = 1'b0;
      chk("R4 pulse single cycle", {31'd0, instr_illegal}, 32'd0);
      chk("R4 no write", {31'd0, rf_we}, 32'd0);
      chk("R7 flags untouched", {27'd0, fflags_acc}, {27'd0, flags_exp});
    end else begin
      chk("R8 core_valid one cycle after accept", {31'd0, core_valid}, 32'd1);
      chk("R4 no illegal on legal", {31'd0, instr_illegal}, 32'd0);
      chk("R5 busy not ready", {31'd0, issue_ready}, 32'd0);
      chk("R2 core_a sign", core_a, {a[31] ^ fa, a[30:0]});
      chk("R2 core_b unchanged", core_b, b);
      chk("R2 core_c sign", core_c, {c[31] ^ fc, c[30:0]});
      chk("R3 rounding mode", {29'd0, core_rm}, {29'd0, eff});
      for (int k = 0; k < cdly; k++) begin
        @(negedge clk);
        chk("R5 valid held", {31'd0, core_valid}, 32'd1);
        chk("R5 payload held", core_c, {c[31] ^ fc, c[30:0]});
      end
      core_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      core_ready = 1'b0;
      chk("R6 res_ready after send", {30'd0, core_valid, res_ready}, 32'd1);
      for (int k = 0; k < rdly; k++) begin
        @(negedge clk);
        chk("R6 no early write", {30'd0, rf_we, res_ready}, 32'd1);
      end
      res_valid = 1'b1;
      res_value = rv;
      res_flags = rf;
      @(posedge clk);
      @(negedge clk);
      res_valid = 1'b0;
      flags_exp = flags_exp | rf;
      chk("R6 write enable", {31'd0, rf_we}, 32'd1);
      chk("R6 write index", {27'd0, rf_waddr}, {27'd0, rd});
      chk("R6 write data", rf_wdata, rv);
      chk("R7 flags accrued", {27'd0, fflags_acc}, {27'd0, flags_exp});
      chk("R8 idle at write", {31'd0, issue_ready}, 32'd1);
      @(negedge clk);
      chk("R6 write single pulse", {31'd0, rf_we}, 32'd0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual=hung expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [6:0] opcs [4];
    logic [6:0] bad  [4];
    int idx;
    opcs[0] = 7'b1000011; opcs[1] = 7'b1000111;
    opcs[2] = 7'b1001011; opcs[3] = 7'b1001111;
    bad[0]  = 7'b0000011; bad[1]  = 7'b1010011;
    bad[2]  = 7'b1000001; bad[3]  = 7'b1001110;
    idx = 0;
    do_reset();

    for (int o = 0; o < 4; o++) begin
      for (int rm = 0; rm < 8; rm++) begin
        for (int f = 0; f < ((rm == 7) ? 8 : 1); f++) begin
          logic [31:0] a, b, c;
          logic [4:0]  fl;
          a  = 32'h3f80_0000 + idx * 32'h0101_0101;
          b  = 32'hc040_0000 ^ (idx * 32'h0003_0007);
          c  = 32'h4120_0000 + idx * 32'h0011_0000;
          if (idx % 5 == 0) a = 32'h7fc0_0000;
          if (idx % 7 == 0) c = 32'hff80_0000;
          fl = (idx % 4 == 0) ? 5'(1 << (idx % 5)) : 5'd0;
          run_op(opcs[o], 2'b00, 3'(rm), (rm == 7) ? 3'(f) : 3'((rm * 3) % 8),
                 5'(idx), 5'(idx + 1), 5'(idx + 9), 5'(idx + 17),
                 a, b, c, idx % 3, (idx / 3) % 3,
                 32'h5a00_0000 ^ (idx * 32'h0000_1357), fl);
          idx++;
        end
      end
      // illegal format widths for this opcode
      for (int fm = 1; fm < 4; fm++)
        run_op(opcs[o], 2'(fm), 3'b000, 3'b000, 5'd3, 5'd4, 5'd5, 5'd6,
               32'h1, 32'h2, 32'h3, 0, 0, 32'h0, 5'h1f);
      do_reset();
    end

    for (int k = 0; k < 4; k++)
      run_op(bad[k], 2'b00, 3'b001, 3'b000, 5'd7, 5'd8, 5'd9, 5'd10,
             32'h4000_0000, 32'h4000_0000, 32'h4000_0000, 0, 0, 32'h0, 5'h1f);

    // accrual across successive retirements, all flag bits
    run_op(7'b1000011, 2'b00, 3'b000, 3'b000, 5'd31, 5'd0, 5'd0, 5'd0,
           32'h0, 32'h0, 32'h8000_0000, 2, 2, 32'h1234_5678, 5'b00011);
    run_op(7'b1001111, 2'b00, 3'b111, 3'b100, 5'd30, 5'd1, 5'd2, 5'd3,
           32'hff80_0000, 32'h7f80_0000, 32'h7fc0_0001, 1, 0, 32'h8765_4321, 5'b10100);
    run_op(7'b1000111, 2'b00, 3'b111, 3'b110, 5'd1, 5'd2, 5'd3, 5'd4,
           32'h1, 32'h1, 32'h1, 0, 0, 32'h0, 5'h1f);
    chk("R7 all flags after accrual", {27'd0, fflags_acc}, 32'h17);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule